// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

The block is a small programmable two-plane logic array with three inputs, four product-term lines and three outputs. The first plane builds each product from any chosen mix of true and complemented inputs. The second plane ORs any chosen subset of the four products into each output. Products are shared between outputs, so three functions can be served by only four AND terms. The cost is that a function set needing more than four distinct products cannot be programmed.

Both planes live in a 36-bit configuration image. The image is loaded one bit per clock over a serial port, and the outputs are purely combinational from the inputs and the active image. A new image replaces the old one only after its last bit arrives. A synchronous reset installs a built-in default image that realises three example functions with four shared products.

Top module: `pla_array`

## Requirements
- R1: After reset, with the input code read as {in_x[2], in_x[1], in_x[0]} = {x, y, z}, out_v[2] is 1 exactly for codes 1, 2, 3, 4, out_v[1] exactly for codes 2, 6, 7, and out_v[0] exactly for codes 4, 6, 7.
- R2: Product p uses image bits 6p to 6p+5. Bit 6p+2i set makes the product require in_x[i] = 1, and bit 6p+2i+1 set makes it require in_x[i] = 0. The product is the AND of all such requirements.
- R3: If both selection bits of any input are set for a product, that product is 0 for every input code.
- R4: A product with none of its six selection bits set is 1 for every input code.
- R5: out_v[o] is the OR of every product p whose image bit 24 + 4o + p is set. An output with none of its four bits set is 0.
- R6: While cfg_en is high, cfg_bit is shifted in once per clock. The k-th bit shifted after reset or after the previous complete load (k from 0) becomes image bit k, so bits 0 to 23 form the AND plane and bits 24 to 35 form the OR plane.
- R7: The outputs keep following the previous image while 35 or fewer bits of a new image have been shifted. They follow the new image from the clock edge that takes the 36th bit.
- R8: While cfg_en is low, no bit is taken and the count of bits shifted is held, so a load may pause and resume.
- R9: A reset during a load discards the bits already shifted. The next 36 shifted bits then form a complete image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, installs default image |
| cfg_en | input | 1 | Serial load enable |
| cfg_bit | input | 1 | Serial configuration data bit |
| in_x | input | 3 | Logic inputs, bit 2 is x, bit 1 is y, bit 0 is z |
| out_v | output | 3 | Combinational outputs of the array |

## Verification
Every programmed image is checked on all eight input codes, so each product and output is seen both asserted and not. The default image is compared against its three minterm lists. Random images drawn from a fixed seed cover mixed literal selections and overlapping OR rows. Directed images isolate a conflicting literal pair, an empty product, an empty OR row and a single literal, which separate the R3, R4 and R5 rules from the general case. Loads that are cut short, paused, or broken by a reset show whether the bit order and the switch-over edge are right.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int PLA_IN   = 3;
  localparam int PLA_PROD = 4;
  localparam int PLA_OUT  = 3;
  localparam int PLA_AND_W = 2 * PLA_IN * PLA_PROD;
  localparam int PLA_OR_W  = PLA_PROD * PLA_OUT;
  localparam int PLA_IMG_W = PLA_AND_W + PLA_OR_W;

  // Default products: p0 = x y' z', p1 = x y, p2 = x' z, p3 = x' y z'
  localparam logic [PLA_AND_W-1:0] PLA_DEF_AND =
    {6'b100110, 6'b100001, 6'b010100, 6'b011010};
  // Rows {out2, out1, out0}: out2 = p0+p2+p3, out1 = p1+p3, out0 = p0+p1
  localparam logic [PLA_OR_W-1:0] PLA_DEF_OR = {4'b1101, 4'b1010, 4'b0011};
  localparam logic [PLA_IMG_W-1:0] PLA_DEF_IMG = {PLA_DEF_OR, PLA_DEF_AND};
endpackage

// File: rtl/pla_cfg_loader.sv
module pla_cfg_loader #(
  parameter int IMG_W = pla_pkg::PLA_IMG_W,
  parameter logic [IMG_W-1:0] DEF_IMG = pla_pkg::PLA_DEF_IMG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  output logic [IMG_W-1:0] img
);
  localparam int CNT_W = $clog2(IMG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IMG_W - 1);

  logic [IMG_W-1:0] shift_q;
  logic [CNT_W-1:0] cnt_q;

  wire              final_bit = cfg_en && (cnt_q == LAST);
  wire [IMG_W-1:0]  shift_nx  = {cfg_bit, shift_q[IMG_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      cnt_q   <= '0;
      img     <= DEF_IMG;
    end else if (cfg_en) begin
      shift_q <= shift_nx;
      cnt_q   <= final_bit ? '0 : cnt_q + 1'b1;
      if (final_bit) img <= shift_nx;
    end
  end

  assert_reset_default_R1: assert property (@(posedge clk) rst |=> (img == DEF_IMG));
  assert_count_range_R6: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);
  assert_hold_image_R7: assert property (@(posedge clk) disable iff (rst)
    !final_bit |=> $stable(img));
  assert_pause_R8: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cnt_q));
  assert_reset_count_R9: assert property (@(posedge clk) rst |=> (cnt_q == '0));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = pla_pkg::PLA_IN,
  parameter int N_PROD = pla_pkg::PLA_PROD
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2*N_IN*N_PROD-1:0] and_bits,
  input  logic [N_IN-1:0]          in_x,
  output logic [N_PROD-1:0]        prod
);
  localparam int ROW_W = 2 * N_IN;

  function automatic logic term_eval(input logic [ROW_W-1:0] row, input logic [N_IN-1:0] v);
    logic r;
    r = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (row[2*i]   && !v[i]) r = 1'b0;
      if (row[2*i+1] &&  v[i]) r = 1'b0;
    end
    return r;
  endfunction

  for (genvar p = 0; p < N_PROD; p++) begin : g_term
    wire [ROW_W-1:0] row = and_bits[p*ROW_W +: ROW_W];
    logic conflict;
    always_comb begin
      conflict = 1'b0;
      for (int i = 0; i < N_IN; i++) conflict |= row[2*i] & row[2*i+1];
    end
    assign prod[p] = term_eval(row, in_x);

    assert_conflict_zero_R3: assert property (@(posedge clk) disable iff (rst)
      conflict |-> !prod[p]);
    assert_empty_one_R4: assert property (@(posedge clk) disable iff (rst)
      (row == '0) |-> prod[p]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_PROD = pla_pkg::PLA_PROD,
  parameter int N_OUT  = pla_pkg::PLA_OUT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_PROD*N_OUT-1:0] or_bits,
  input  logic [N_PROD-1:0]       prod,
  output logic [N_OUT-1:0]        out_v
);
  function automatic logic sum_eval(input logic [N_PROD-1:0] row, input logic [N_PROD-1:0] t);
    return |(row & t);
  endfunction

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    wire [N_PROD-1:0] row = or_bits[o*N_PROD +: N_PROD];
    assign out_v[o] = sum_eval(row, prod);

    assert_empty_or_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (row == '0) |-> !out_v[o]);
    assert_selected_term_R5: assert property (@(posedge clk) disable iff (rst)
      (|(row & prod)) |-> out_v[o]);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = pla_pkg::PLA_IN,
  parameter int N_PROD = pla_pkg::PLA_PROD,
  parameter int N_OUT  = pla_pkg::PLA_OUT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  input  logic [N_IN-1:0]  in_x,
  output logic [N_OUT-1:0] out_v
);
  localparam int AND_W = 2 * N_IN * N_PROD;
  localparam int OR_W  = N_PROD * N_OUT;
  localparam int IMG_W = AND_W + OR_W;

  logic [IMG_W-1:0]  img;
  logic [N_PROD-1:0] prod;

  pla_cfg_loader #(.IMG_W(IMG_W), .DEF_IMG(IMG_W'(pla_pkg::PLA_DEF_IMG))) u_load (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .img(img)
  );

  pla_and_plane #(.N_IN(N_IN), .N_PROD(N_PROD)) u_and (
    .clk(clk), .rst(rst), .and_bits(img[AND_W-1:0]), .in_x(in_x), .prod(prod)
  );

  pla_or_plane #(.N_PROD(N_PROD), .N_OUT(N_OUT)) u_or (
    .clk(clk), .rst(rst), .or_bits(img[IMG_W-1:AND_W]), .prod(prod), .out_v(out_v)
  );
endmodule

// File: tb/pla_array_test.sv
module pla_array_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic cfg_bit = 1'b0;
  logic [2:0] in_x = '0;
  logic [2:0] out_v;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pla_array uut (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
                 .in_x(in_x), .out_v(out_v));

  // Reference: a product fails if any selected literal disagrees with the input.
  function automatic logic [2:0] model(input logic [35:0] im, input logic [2:0] code);
    logic [3:0] pt;
    logic [2:0] r;
    for (int p = 0; p < 4; p++) begin
      int miss = 0;
      for (int i = 0; i < 3; i++) begin
        if (im[6*p+2*i]   == 1'b1 && code[i] == 1'b0) miss++;
        if (im[6*p+2*i+1] == 1'b1 && code[i] == 1'b1) miss++;
      end
      pt[p] = (miss == 0);
    end
    r = '0;
    for (int o = 0; o < 3; o++)
      for (int p = 0; p < 4; p++)
        if (im[24+4*o+p] && pt[p]) r[o] = 1'b1;
    return r;
  endfunction

  function automatic logic [2:0] minterm_ref(input logic [2:0] code);
    logic [7:0] m2 = 8'b0001_1110;
    logic [7:0] m1 = 8'b1100_0100;
    logic [7:0] m0 = 8'b1101_0000;
    return {m2[code], m1[code], m0[code]};
  endfunction

  task automatic cmp(input logic [2:0] act, input logic [2:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s code=%0d actual=%b expected=%b", req, in_x, act, exp);
    end
  endtask

  task automatic check_img(input logic [35:0] im, input string req);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      in_x = 3'(c);
      #1;
      cmp(out_v, model(im, 3'(c)), req);
    end
  endtask

  task automatic shift_bits(input logic [35:0] im, input int first, input int count);
    for (int k = first; k < first + count; k++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_bit = im[k];
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  logic [35:0] def_img, img_a, img_b;

  initial begin
    def_img = {12'b1101_1010_0011, 24'b100110_100001_010100_011010};
    void'($urandom(32'h1234_5EED));
    do_reset();

    // R1: default program against the three minterm lists
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      in_x = 3'(c);
      #1;
      cmp(out_v, minterm_ref(3'(c)), "R1");
    end

    // R2 R5 R6: random images
    for (int n = 0; n < 8; n++) begin
      img_a = 36'({$urandom(), $urandom()});
      shift_bits(img_a, 0, 36);
      check_img(img_a, "R2/R5/R6");
    end

    // R2: single true literal x in p0, routed to all outputs; other products conflict
    img_a = {12'b0001_0001_0001, 6'b000011, 6'b000011, 6'b000011, 6'b010000};
    shift_bits(img_a, 0, 36);
    check_img(img_a, "R2");

    // R3: conflicting pair on y in p2 only; out1 uses p2 alone
    img_a = {12'b0001_0100_1111, 6'b000000, 6'b001100, 6'b000000, 6'b000000};
    shift_bits(img_a, 0, 36);
    check_img(img_a, "R3");
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      in_x = 3'(c);
      #1;
      cmp({1'b0, out_v[1], 1'b0}, 3'b000, "R3");
    end

    // R4: empty product p3 drives out2; out0 from empty OR row
    img_a = {12'b1000_0110_0000, 6'b000000, 6'b100000, 6'b000001, 6'b111111};
    shift_bits(img_a, 0, 36);
    check_img(img_a, "R4");
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      in_x = 3'(c);
      #1;
      cmp({out_v[2], 1'b0, out_v[0]}, 3'b100, "R4/R5");
    end

    // R7: 35 bits shifted leaves old image active, 36th switches
    img_b = 36'({$urandom(), $urandom()}) ^ img_a;
    shift_bits(img_b, 0, 35);
    check_img(img_a, "R7");
    shift_bits(img_b, 35, 1);
    check_img(img_b, "R7");

    // R8: pause mid-load; old image stays, count resumes
    img_a = ~img_b;
    shift_bits(img_a, 0, 17);
    repeat (5) @(negedge clk);
    check_img(img_b, "R8");
    shift_bits(img_a, 17, 19);
    check_img(img_a, "R8");

    // R9: reset mid-load discards partial bits
    img_b = 36'({$urandom(), $urandom()});
    shift_bits(img_b, 0, 20);
    do_reset();
    check_img(def_img, "R9");
    shift_bits(img_b, 0, 36);
    check_img(img_b, "R9");

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule